// File: doc/BRIEF.md
# Paired Register Move Expander

This block turns one compressed double-move instruction into two single register-move micro-ops. It works in either direction: it copies the two argument registers (x10, x11) into two saved registers, or it copies two saved registers into the argument registers. The instruction names each saved register with a 3-bit code. The block widens each code to a 5-bit register index. Code 0 becomes x8 and code 1 becomes x9. Codes 2 to 7 become x18 to x23.

The block checks each instruction for legality before it issues anything. An illegal instruction produces no micro-ops. Instead it raises a one-cycle illegal flag.

A legal instruction produces two micro-ops on a valid/ready output stream. The pipeline must treat the pair as one unit that cannot be split. To make that possible, the block raises an interrupt-hold signal from the cycle the first move is offered until the cycle the second move is accepted. Both register indices are captured when the instruction is accepted. The register file and the execution of the moves are outside the block.

Back-pressure works as follows:
- The instruction input is valid/ready. It is accepted on a cycle where both `in_valid` and `in_ready` are high.
- `in_ready` is high only when no pair is in flight.
- A micro-op is offered while `uop_valid` is high. It stays stable until the cycle in which `uop_ready` is high.

Top module: `mvpair_expander`

## Requirements
- R1: Each 3-bit code c maps to register index {c[2:1]!=0, c[2:1]==0, c[2:0]}. Codes 0..7 give x8, x9, x18, x19, x20, x21, x22, x23.
- R2: When `in_dir`=0 (argument to saved), the first micro-op is src x10 to dst map(r1). The second is src x11 to dst map(r2).
- R3: When `in_dir`=1 (saved to argument), the first micro-op is src map(r1) to dst x10. The second is src map(r2) to dst x11.
- R4: When `in_rv32e`=1, a code greater than 1 in either specifier makes the instruction illegal.
- R5: Equal specifiers are illegal when `in_dir`=0 and legal when `in_dir`=1.
- R6: An illegal instruction raises `illegal` for exactly one cycle, in the cycle after acceptance. It emits no micro-op.
- R7: `irq_hold` is high from the first cycle the first micro-op is offered until the cycle the second micro-op is accepted. It is low otherwise.
- R8: While `uop_valid` is high and `uop_ready` is low, the offered micro-op holds its src, dst and `uop_last` unchanged.
- R9: `in_ready` is low while a pair is in flight. The first micro-op appears in the cycle after acceptance. `uop_last`=1 marks the second micro-op.
- R10: After reset, `uop_valid`, `illegal` and `irq_hold` are 0 and `in_ready` is 1.
- R11: The second micro-op's source register never equals the first micro-op's destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_r1 | input | 3 | First saved-register code |
| in_r2 | input | 3 | Second saved-register code |
| in_dir | input | 1 | 0: argument to saved, 1: saved to argument |
| in_rv32e | input | 1 | Reduced register file mode |
| uop_valid | output | 1 | Micro-op offered |
| uop_ready | input | 1 | Micro-op accepted when high with uop_valid |
| uop_src | output | 5 | Source register index |
| uop_dst | output | 5 | Destination register index |
| uop_last | output | 1 | Marks the second micro-op of the pair |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| irq_hold | output | 1 | Interrupts must be held off |

## Verification
The vector table covers the following input patterns:
- Both directions, with every code 0..7 appearing as a source or a destination, so a wrong bit in the index mapping shows up as a wrong register.
- Equal specifiers in each direction, which distinguishes the direction-dependent legality rule.
- Reduced-mode instructions with codes below and above 1, which separate the reduced-mode check from the equal-specifier check.

Directed tests follow the table:
- A stalled pair shows that the offered micro-op and `irq_hold` persist under back-pressure, and that new instructions are refused.
- A reset during a pair shows that the block returns to idle.

// File: rtl/mvp_pkg.sv
package mvp_pkg;
  localparam int SPEC_W = 3;
  localparam int REG_W  = 5;
  localparam int NMOVES = 2;
  localparam int RV32E_MAX = 1;
  localparam logic [REG_W-1:0] ARG0 = 5'd10;
  localparam logic [REG_W-1:0] ARG1 = 5'd11;

  typedef struct packed {
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
  } move_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seq_state_e;

  function automatic logic [REG_W-1:0] widen_spec(input logic [SPEC_W-1:0] c);
    return {|c[2:1], ~|c[2:1], c};
  endfunction
endpackage

// File: rtl/mvp_decode.sv
module mvp_decode
  import mvp_pkg::*;
(
  input  logic [SPEC_W-1:0] r1,
  input  logic [SPEC_W-1:0] r2,
  input  logic              dir_to_arg,
  input  logic              rv32e,
  output move_t             moves [NMOVES],
  output logic              bad
);
  logic [SPEC_W-1:0] spec [NMOVES];
  logic [REG_W-1:0]  arg  [NMOVES];
  logic [NMOVES-1:0] over_e;

  assign spec[0] = r1;
  assign spec[1] = r2;
  assign arg[0]  = ARG0;
  assign arg[1]  = ARG1;

  for (genvar k = 0; k < NMOVES; k++) begin : g_move
    logic [REG_W-1:0] sreg;
    assign sreg      = widen_spec(spec[k]);
    assign over_e[k] = rv32e && (int'(spec[k]) > RV32E_MAX);
    always_comb begin
      if (dir_to_arg) begin
        moves[k].src = sreg;
        moves[k].dst = arg[k];
      end else begin
        moves[k].src = arg[k];
        moves[k].dst = sreg;
      end
    end
  end

  assign bad = (|over_e) || (!dir_to_arg && (r1 == r2));
endmodule

// File: rtl/mvp_sequencer.sv
module mvp_sequencer
  import mvp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_valid,
  output logic             accept_ready,
  input  move_t            moves_in [NMOVES],
  input  logic             bad_in,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [REG_W-1:0] uop_src,
  output logic [REG_W-1:0] uop_dst,
  output logic             uop_last,
  output logic             illegal,
  output logic             irq_hold
);
  seq_state_e state_q, state_d;
  move_t      held_q [NMOVES];
  logic       bad_q;
  logic       take;
  move_t      cur;

  assign accept_ready = (state_q == ST_IDLE);
  assign take         = accept_valid && accept_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (take && !bad_in) state_d = ST_FIRST;
      ST_FIRST:  if (uop_ready) state_d = ST_SECOND;
      ST_SECOND: if (uop_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_q   <= take && bad_in;
    end
  end

  for (genvar k = 0; k < NMOVES; k++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                held_q[k] <= '0;
      else if (take && !bad_in)  held_q[k] <= moves_in[k];
    end
  end

  assign cur       = (state_q == ST_SECOND) ? held_q[1] : held_q[0];
  assign uop_valid = (state_q != ST_IDLE);
  assign uop_src   = cur.src;
  assign uop_dst   = cur.dst;
  assign uop_last  = (state_q == ST_SECOND);
  assign illegal   = bad_q;
  assign irq_hold  = (state_q != ST_IDLE);
endmodule

// File: rtl/mvpair_expander.sv
module mvpair_expander
  import mvp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SPEC_W-1:0] in_r1,
  input  logic [SPEC_W-1:0] in_r2,
  input  logic             in_dir,
  input  logic             in_rv32e,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [REG_W-1:0] uop_src,
  output logic [REG_W-1:0] uop_dst,
  output logic             uop_last,
  output logic             illegal,
  output logic             irq_hold
);
  move_t dec_moves [NMOVES];
  logic  dec_bad;

  mvp_decode u_decode (
    .r1(in_r1), .r2(in_r2), .dir_to_arg(in_dir), .rv32e(in_rv32e),
    .moves(dec_moves), .bad(dec_bad)
  );

  mvp_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .accept_valid(in_valid), .accept_ready(in_ready),
    .moves_in(dec_moves), .bad_in(dec_bad),
    .uop_valid(uop_valid), .uop_ready(uop_ready),
    .uop_src(uop_src), .uop_dst(uop_dst), .uop_last(uop_last),
    .illegal(illegal), .irq_hold(irq_hold)
  );
endmodule

// File: rtl/mvpair_expander_checker.sv
module mvpair_expander_checker
  import mvp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             uop_valid,
  input logic             uop_ready,
  input logic [REG_W-1:0] uop_src,
  input logic [REG_W-1:0] uop_dst,
  input logic             uop_last,
  input logic             illegal,
  input logic             irq_hold
);
  assert_saved_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && (uop_src == ARG0 || uop_src == ARG1)) |->
      (uop_dst inside {5'd8, 5'd9, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23}));

  assert_illegal_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  assert_illegal_no_uop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !uop_valid);

  assert_hold_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> irq_hold);

  assert_second_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_last && uop_ready) |=> (uop_valid && uop_last && irq_hold));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_last && uop_ready) |=> !irq_hold);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=>
      (uop_valid && $stable(uop_src) && $stable(uop_dst) && $stable(uop_last)));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hold |-> !in_ready);

  assert_no_clobber_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_last && uop_ready) |=> (uop_src != $past(uop_dst)));
endmodule

bind mvpair_expander mvpair_expander_checker i_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .uop_valid(uop_valid), .uop_ready(uop_ready),
  .uop_src(uop_src), .uop_dst(uop_dst), .uop_last(uop_last),
  .illegal(illegal), .irq_hold(irq_hold)
);

// File: tb/test_mvpair_expander.sv
module test_mvpair_expander;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  localparam int VW = 29;

  function automatic logic [VW-1:0] mk(input logic d, input logic e, input logic [2:0] a,
      input logic [2:0] b, input logic il, input logic [4:0] s1, input logic [4:0] d1,
      input logic [4:0] s2, input logic [4:0] d2);
    return {d, e, a, b, il, s1, d1, s2, d2};
  endfunction

  // {dir, rv32e, r1, r2, illegal, src1, dst1, src2, dst2}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    mk(0, 0, 0, 1, 0, 10,  8, 11,  9),  // R2 R1
    mk(0, 0, 7, 2, 0, 10, 23, 11, 18),  // R2 R1
    mk(0, 0, 3, 4, 0, 10, 19, 11, 20),  // R2 R1
    mk(0, 0, 5, 6, 0, 10, 21, 11, 22),  // R2 R1
    mk(1, 0, 1, 0, 0,  9, 10,  8, 11),  // R3
    mk(1, 0, 6, 6, 0, 22, 10, 22, 11),  // R3 R5 equal legal
    mk(1, 0, 2, 7, 0, 18, 10, 23, 11),  // R3
    mk(0, 0, 4, 4, 1,  0,  0,  0,  0),  // R5 equal illegal
    mk(0, 1, 1, 0, 0, 10,  9, 11,  8),  // R4 legal in rv32e
    mk(1, 1, 0, 2, 1,  0,  0,  0,  0),  // R4
    mk(1, 1, 0, 0, 0,  8, 10,  8, 11),  // R4 R5
    mk(0, 1, 3, 1, 1,  0,  0,  0,  0),  // R4
    mk(0, 1, 1, 1, 1,  0,  0,  0,  0)   // R5 in rv32e
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_dir = 0, in_rv32e = 0, uop_ready = 1;
  logic [2:0] in_r1 = 0, in_r2 = 0;
  logic uop_valid, uop_last, illegal, irq_hold;
  logic [4:0] uop_src, uop_dst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvpair_expander i_mvpair_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r1(in_r1), .in_r2(in_r2), .in_dir(in_dir), .in_rv32e(in_rv32e),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_src(uop_src), .uop_dst(uop_dst),
    .uop_last(uop_last), .illegal(illegal), .irq_hold(irq_hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // state word: {uop_valid, uop_last, irq_hold, illegal, src, dst}
  function automatic logic [31:0] obs();
    return {18'd0, uop_valid, uop_last, irq_hold, illegal, uop_src, uop_dst};
  endfunction

  function automatic logic [31:0] want(input logic v, input logic l, input logic h,
      input logic il, input logic [4:0] s, input logic [4:0] d);
    return {18'd0, v, l, h, il, s, d};
  endfunction

  task automatic issue(input logic d, input logic e, input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    in_valid = 1; in_dir = d; in_rv32e = e; in_r1 = a; in_r2 = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", obs() & 32'h3C00, 32'h0);
    chk("R10 reset in_ready", {31'd0, in_ready}, 1);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      issue(v[28], v[27], v[26:24], v[23:21]);
      if (v[20]) begin
        chk("R6 illegal pulse", obs() & 32'h3C00, want(0, 0, 0, 1, 0, 0));
        @(negedge clk);
        chk("R6 illegal gone", obs() & 32'h3C00, 32'h0);
      end else begin
        chk("R2/R3 first move R9", obs(), want(1, 0, 1, 0, v[19:15], v[14:10]));
        chk("R9 busy", {31'd0, in_ready}, 0);
        @(negedge clk);
        chk("R2/R3 second move R11", obs(), want(1, 1, 1, 0, v[9:5], v[4:0]));
        @(negedge clk);
        chk("R7 released", obs() & 32'h3C00, 32'h0);
      end
    end

    // R8: back-pressure on the first and second move; R9 refuses new input
    uop_ready = 0;
    issue(1, 0, 5, 3);
    repeat (2) @(negedge clk);
    chk("R8 stall first", obs(), want(1, 0, 1, 0, 21, 10));
    chk("R7 hold during stall", {31'd0, irq_hold}, 1);
    in_valid = 1; in_dir = 0; in_r1 = 0; in_r2 = 0;
    @(negedge clk);
    in_valid = 0;
    chk("R9 ignored while busy", obs(), want(1, 0, 1, 0, 21, 10));
    uop_ready = 1;
    @(negedge clk);
    uop_ready = 0;
    chk("R8 second offered", obs(), want(1, 1, 1, 0, 19, 11));
    repeat (2) @(negedge clk);
    chk("R8 stall second", obs(), want(1, 1, 1, 0, 19, 11));
    uop_ready = 1;
    @(negedge clk);
    chk("R7 release after stall", obs() & 32'h3C00, 32'h0);

    // R10: reset mid-pair
    uop_ready = 0;
    issue(0, 0, 2, 3);
    rst_n = 0;
    @(negedge clk);
    chk("R10 reset mid-pair", obs() & 32'h3C00, 32'h0);
    chk("R10 in_ready after reset", {31'd0, in_ready}, 1);
    rst_n = 1; uop_ready = 1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule